// File: doc/BRIEF.md
# Ping-Pong Receive DMA Controller

This block drains a serial receiver's byte FIFO into memory through two buffers, A and B, that take turns. Software arms a buffer with a one-cycle strobe that also captures that buffer's start address and byte length. The controller writes each byte it takes from the FIFO at the armed buffer's start address plus the number of bytes already written there. When a buffer has received its last byte, the controller moves on to the other buffer if that one is armed. If it is not, the controller stops popping the FIFO.

For each buffer the block keeps sticky flags for frame errors, parity errors and receive overflow. A buffer's flags are cleared when that buffer is armed again. In SPI slave mode, a deassertion of slave select stores the byte count of the buffer in use at that moment. It also stores a 3-bit code that tells which buffer that was and whether more than one deassertion has occurred since the code was last cleared. A synchronous receive DMA reset puts all of this state back to idle in one cycle.

Top module: `rx_pingpong_dma`

## Requirements
- R1: A strobe on `arm_a`/`arm_b` accepted while that buffer is idle, with a nonzero length, captures the base and length and sets `load_a`/`load_b` to 1 on the next cycle. A strobe with length 0, or a strobe while that buffer's load bit is 1, changes nothing, and the captured base is kept.
- R2: In a cycle where a byte is taken, `fifo_pop` and `mem_we` are 1 and `mem_addr` = base + bytes already written to that buffer. The load bit falls to 0 in the cycle after the buffer's length-th byte.
- R3: If both buffers are armed in the same cycle while both are idle, the first byte goes to buffer A.
- R4: When a buffer completes and the other buffer is armed, the next valid FIFO byte, in the very next cycle, is written at the other buffer's base.
- R5: A byte written with `fifo_frame_err`=1 sets that buffer's `frm` flag, and one written with `fifo_parity_err`=1 sets its `par` flag. Both flags stay set until that same buffer is armed again. The other buffer's flags are unaffected.
- R6: While neither load bit is 1, `fifo_pop` and `mem_we` stay 0 whatever `fifo_valid` is.
- R7: A `fifo_ovf` pulse sets the overflow flag of the buffer being filled. The pulse is dropped when no buffer is armed. The flag clears when that buffer is armed again.
- R8: With `spi_mode`=1, a rising edge of `ssel_n` stores in `saved_count` the bytes written before that cycle to the buffer in use. If no buffer is armed, the buffer that took the most recent byte is used.
- R9: `ssel_state` encoding: 0 = nothing saved; 2/3 = buffer A/B saved after one deassertion; 6/7 = buffer A/B saved after more than one. The values 1, 4 and 5 never appear.
- R10: An accepted arm of either buffer clears `ssel_state` to 0. If an accepted arm and a deassertion fall in the same cycle, the result is the single-deassertion code (2 or 3).
- R11: `dma_reset`=1 clears both load bits, all error and overflow flags, `ssel_state`, `saved_count` and both write counts on the next cycle, and overrides an arm in that same cycle.
- R12: With `spi_mode`=0, slave-select edges leave `ssel_state` and `saved_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_reset | input | 1 | Synchronous receive DMA reset |
| spi_mode | input | 1 | 1 enables slave-select count saving |
| arm_a | input | 1 | Arm strobe for buffer A |
| arm_b | input | 1 | Arm strobe for buffer B |
| a_base | input | AW | Buffer A start address |
| a_len | input | CW | Buffer A length in bytes |
| b_base | input | AW | Buffer B start address |
| b_len | input | CW | Buffer B length in bytes |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | FIFO head byte |
| fifo_frame_err | input | 1 | Head byte has a frame error |
| fifo_parity_err | input | 1 | Head byte has a parity error |
| fifo_ovf | input | 1 | Receiver overflow pulse |
| ssel_n | input | 1 | Slave select, active low |
| fifo_pop | output | 1 | Byte taken from FIFO this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| load_a | output | 1 | Buffer A active or pending |
| load_b | output | 1 | Buffer B active or pending |
| frm_a | output | 1 | Buffer A frame error flag |
| frm_b | output | 1 | Buffer B frame error flag |
| par_a | output | 1 | Buffer A parity error flag |
| par_b | output | 1 | Buffer B parity error flag |
| ovf_a | output | 1 | Buffer A overflow flag |
| ovf_b | output | 1 | Buffer B overflow flag |
| ssel_state | output | 3 | Saved-count status code |
| saved_count | output | CW | Count stored on deassertion |

## Verification
Arming a buffer and a slave-select deassertion can land in the same cycle. The arm wants `ssel_state` cleared and the deassertion wants a record written. The bench causes this collision by raising `ssel_n` in the same cycle as an `arm_a` strobe, with buffer B already holding one byte and an earlier record present. It then expects code 3, not 7, together with a saved count of 1. A second overlap, the last byte of one buffer followed directly by the first byte of the other, is judged by reading the written addresses cycle by cycle.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_e;

  // Saved-count code: bit2 = repeated deassertion, bit1 = valid, bit0 = buffer
  function automatic logic [2:0] ssel_next(input logic [2:0] prior, input buf_e b);
    return {prior != 3'd0, 1'b1, b == BUF_B};
  endfunction
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arm,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] len_in,
  input  logic          wr,
  input  logic          frm_in,
  input  logic          par_in,
  input  logic          ovf_in,
  output logic          busy,
  output logic          loaded,
  output logic          last,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          frm,
  output logic          par,
  output logic          ovf
);
  logic [AW-1:0] base_q;
  logic [CW-1:0] len_q;

  function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] b, input logic [CW-1:0] c);
    return b + AW'(c);
  endfunction

  function automatic logic is_final(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return CW'(c + 1'b1) == l;
  endfunction

  assign loaded = arm && !busy && (len_in != '0) && !clr;
  assign last   = wr && is_final(cnt, len_q);
  assign addr   = addr_of(base_q, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy   <= 1'b0;
      cnt    <= '0;
      frm    <= 1'b0;
      par    <= 1'b0;
      ovf    <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
    end else if (loaded) begin
      busy   <= 1'b1;
      cnt    <= '0;
      frm    <= 1'b0;
      par    <= 1'b0;
      ovf    <= 1'b0;
      base_q <= base_in;
      len_q  <= len_in;
    end else begin
      if (wr) begin
        cnt  <= CW'(cnt + 1'b1);
        busy <= !last;
        frm  <= frm | frm_in;
        par  <= par | par_in;
      end
      if (ovf_in) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_ssel.sv
module rxdma_ssel #(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              spi_mode,
  input  logic              ssel_n,
  input  logic              any_load,
  input  rxdma_pkg::buf_e   act_buf,
  input  logic [CW-1:0]     act_cnt,
  output logic              deassert_evt,
  output logic [2:0]        code,
  output logic [CW-1:0]     saved
);
  import rxdma_pkg::*;
  logic prev_q;

  assign deassert_evt = spi_mode && ssel_n && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= ssel_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      code  <= 3'd0;
      saved <= '0;
    end else if (deassert_evt) begin
      code  <= ssel_next(any_load ? 3'd0 : code, act_buf);
      saved <= act_cnt;
    end else if (any_load) begin
      code  <= 3'd0;
    end
  end
endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_reset,
  input  logic          spi_mode,
  input  logic          arm_a,
  input  logic          arm_b,
  input  logic [AW-1:0] a_base,
  input  logic [CW-1:0] a_len,
  input  logic [AW-1:0] b_base,
  input  logic [CW-1:0] b_len,
  input  logic          fifo_valid,
  input  logic [7:0]    fifo_data,
  input  logic          fifo_frame_err,
  input  logic          fifo_parity_err,
  input  logic          fifo_ovf,
  input  logic          ssel_n,
  output logic          fifo_pop,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          load_a,
  output logic          load_b,
  output logic          frm_a,
  output logic          frm_b,
  output logic          par_a,
  output logic          par_b,
  output logic          ovf_a,
  output logic          ovf_b,
  output logic [2:0]    ssel_state,
  output logic [CW-1:0] saved_count
);
  import rxdma_pkg::*;
  localparam int NBUF = 2;

  // Per-buffer views, index 0 = A, 1 = B
  logic [NBUF-1:0]         arm_v, busy_v, loaded_v, last_v, wr_v, ovf_in_v;
  logic [NBUF-1:0]         frm_v, par_v, ovf_v;
  logic [NBUF-1:0][AW-1:0] base_v, addr_v;
  logic [NBUF-1:0][CW-1:0] len_v, cnt_v;

  // Named internal events for the checker
  buf_e cur_q, lastw_q, sel_b, act_buf;
  logic any_busy, any_load, deassert_evt;

  assign arm_v  = {arm_b, arm_a};
  assign base_v = {b_base, a_base};
  assign len_v  = {b_len, a_len};

  assign any_busy = |busy_v;
  assign any_load = |loaded_v;

  // Stay on the current buffer while it is busy, else the other if busy
  always_comb begin
    if (busy_v[cur_q])        sel_b = cur_q;
    else if (busy_v[!cur_q])  sel_b = buf_e'(!cur_q);
    else                      sel_b = cur_q;
  end

  assign fifo_pop  = fifo_valid && any_busy;
  assign mem_we    = fifo_pop;
  assign mem_addr  = addr_v[sel_b];
  assign mem_wdata = fifo_data;
  assign act_buf   = any_busy ? sel_b : lastw_q;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign wr_v[i]     = fifo_pop && (sel_b == buf_e'(i));
    assign ovf_in_v[i] = fifo_ovf && any_busy && (sel_b == buf_e'(i));

    rxdma_buf #(.AW(AW), .CW(CW)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (dma_reset),
      .arm    (arm_v[i]),
      .base_in(base_v[i]),
      .len_in (len_v[i]),
      .wr     (wr_v[i]),
      .frm_in (fifo_frame_err),
      .par_in (fifo_parity_err),
      .ovf_in (ovf_in_v[i]),
      .busy   (busy_v[i]),
      .loaded (loaded_v[i]),
      .last   (last_v[i]),
      .addr   (addr_v[i]),
      .cnt    (cnt_v[i]),
      .frm    (frm_v[i]),
      .par    (par_v[i]),
      .ovf    (ovf_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || dma_reset) begin
      cur_q   <= BUF_A;
      lastw_q <= BUF_A;
    end else begin
      if (fifo_pop) lastw_q <= sel_b;
      if (!any_busy && any_load)
        cur_q <= loaded_v[0] ? BUF_A : BUF_B;
      else if (|last_v)
        cur_q <= buf_e'(!sel_b);
    end
  end

  rxdma_ssel #(.CW(CW)) u_ssel (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (dma_reset),
    .spi_mode    (spi_mode),
    .ssel_n      (ssel_n),
    .any_load    (any_load),
    .act_buf     (act_buf),
    .act_cnt     (cnt_v[act_buf]),
    .deassert_evt(deassert_evt),
    .code        (ssel_state),
    .saved       (saved_count)
  );

  assign load_a = busy_v[0];
  assign load_b = busy_v[1];
  assign frm_a  = frm_v[0];
  assign frm_b  = frm_v[1];
  assign par_a  = par_v[0];
  assign par_b  = par_v[1];
  assign ovf_a  = ovf_v[0];
  assign ovf_b  = ovf_v[1];
endmodule

// File: rtl/rx_pingpong_dma_chk.sv
module rx_pingpong_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_reset,
  input logic       fifo_pop,
  input logic       load_a,
  input logic       load_b,
  input logic       frm_a,
  input logic       frm_b,
  input logic       par_a,
  input logic       par_b,
  input logic       ovf_a,
  input logic       ovf_b,
  input logic [2:0] ssel_state,
  input logic       sel_b
);
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_a && !load_b) |-> !fifo_pop); // R6

  AST_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(load_a) && $rose(load_b)) |-> (sel_b == 1'b0)); // R3

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ssel_state != 3'd1) && (ssel_state != 3'd4) && (ssel_state != 3'd5)); // R9

  AST_DMA_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_reset) |-> (!load_a && !load_b && ssel_state == 3'd0 &&
      !frm_a && !frm_b && !par_a && !par_b && !ovf_a && !ovf_b)); // R11

  AST_RELOAD_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_a) |-> (!frm_a && !par_a && !ovf_a)); // R5

  AST_RELOAD_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_b) |-> (!frm_b && !par_b && !ovf_b)); // R7
endmodule

bind rx_pingpong_dma rx_pingpong_dma_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dma_reset (dma_reset),
  .fifo_pop  (fifo_pop),
  .load_a    (load_a),
  .load_b    (load_b),
  .frm_a     (frm_a),
  .frm_b     (frm_b),
  .par_a     (par_a),
  .par_b     (par_b),
  .ovf_a     (ovf_a),
  .ovf_b     (ovf_b),
  .ssel_state(ssel_state),
  .sel_b     (sel_b)
);

// File: tb/rx_pingpong_dma_test.sv
module rx_pingpong_dma_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_reset = 1'b0, spi_mode = 1'b0, arm_a = 1'b0, arm_b = 1'b0;
  logic [15:0] a_base = '0, b_base = '0;
  logic [7:0]  a_len = '0, b_len = '0;
  logic fifo_valid = 1'b0, fifo_frame_err = 1'b0, fifo_parity_err = 1'b0, fifo_ovf = 1'b0;
  logic [7:0] fifo_data = '0;
  logic ssel_n = 1'b1;
  logic fifo_pop, mem_we, load_a, load_b, frm_a, frm_b, par_a, par_b, ovf_a, ovf_b;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, saved_count;
  logic [2:0]  ssel_state;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_pingpong_dma uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm(input bit ea, input bit eb, input logic [15:0] ba, input logic [7:0] la,
                     input logic [15:0] bb, input logic [7:0] lb);
    arm_a = ea; arm_b = eb; a_base = ba; a_len = la; b_base = bb; b_len = lb;
    @(negedge clk);
    arm_a = 1'b0; arm_b = 1'b0;
  endtask

  task automatic push(input string req, input bit fe, input bit pe, input bit exp_pop,
                      input logic [15:0] exp_addr);
    fifo_valid = 1'b1; fifo_data = exp_addr[7:0] ^ 8'h5A;
    fifo_frame_err = fe; fifo_parity_err = pe;
    #1;
    chk(req, {fifo_pop, mem_we}, {exp_pop, exp_pop});
    if (exp_pop) begin
      chk(req, mem_addr, exp_addr);
      chk(req, mem_wdata, exp_addr[7:0] ^ 8'h5A);
    end
    @(negedge clk);
    fifo_valid = 1'b0; fifo_frame_err = 1'b0; fifo_parity_err = 1'b0;
  endtask

  task automatic deassert();
    ssel_n = 1'b0;
    @(negedge clk);
    ssel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset loads", {load_a, load_b}, 2'b00);
    chk("R9 reset code", ssel_state, 3'd0);
    push("R6 idle no pop", 0, 0, 0, 16'h0);
  endtask

  task automatic t_fill();
    arm(1, 0, 16'h0100, 8'd3, 16'h0, 8'd0);
    chk("R1 arm sets load_a", load_a, 1'b1);
    push("R2 byte0", 0, 0, 1, 16'h0100);
    push("R2 byte1", 0, 0, 1, 16'h0101);
    chk("R2 not done", load_a, 1'b1);
    push("R2 byte2", 0, 0, 1, 16'h0102);
    chk("R2 load_a clears", load_a, 1'b0);
    push("R6 after done", 0, 0, 0, 16'h0);
    arm(1, 0, 16'h0200, 8'd0, 16'h0, 8'd0);
    chk("R1 zero length ignored", load_a, 1'b0);
    arm(1, 0, 16'h0200, 8'd2, 16'h0, 8'd0);
    arm(1, 0, 16'h0300, 8'd5, 16'h0, 8'd0);
    push("R1 re-arm while busy ignored", 0, 0, 1, 16'h0200);
    push("R1 length kept", 0, 0, 1, 16'h0201);
    chk("R1 length kept done", load_a, 1'b0);
  endtask

  task automatic t_prio();
    arm(1, 1, 16'h0400, 8'd1, 16'h0500, 8'd1);
    chk("R3 both armed", {load_a, load_b}, 2'b11);
    push("R3 A first", 0, 0, 1, 16'h0400);
    push("R3 then B", 0, 0, 1, 16'h0500);
    chk("R3 both done", {load_a, load_b}, 2'b00);
  endtask

  task automatic t_ping();
    arm(1, 1, 16'h0600, 8'd2, 16'h0700, 8'd2);
    push("R4 A0", 0, 0, 1, 16'h0600);
    push("R4 A1", 0, 0, 1, 16'h0601);
    push("R4 B0 next cycle", 0, 0, 1, 16'h0700);
    push("R4 B1", 0, 0, 1, 16'h0701);
    push("R6 stop when none armed", 0, 0, 0, 16'h0);
    arm(0, 1, 16'h0, 8'd0, 16'h0800, 8'd1);
    push("R4 B alone", 0, 0, 1, 16'h0800);
    arm(1, 0, 16'h0900, 8'd1, 16'h0, 8'd0);
    push("R4 A alone", 0, 0, 1, 16'h0900);
  endtask

  task automatic t_err();
    arm(1, 0, 16'h0010, 8'd3, 16'h0, 8'd0);
    push("R5 frame byte", 1, 0, 1, 16'h0010);
    chk("R5 frm_a set", {frm_a, par_a}, 2'b10);
    push("R5 parity byte", 0, 1, 1, 16'h0011);
    chk("R5 par_a set", {frm_a, par_a}, 2'b11);
    chk("R5 B untouched", {frm_b, par_b}, 2'b00);
    push("R5 clean byte", 0, 0, 1, 16'h0012);
    chk("R5 sticky", {frm_a, par_a}, 2'b11);
    arm(1, 0, 16'h0020, 8'd1, 16'h0, 8'd0);
    chk("R5 reload clears", {frm_a, par_a}, 2'b00);
    push("R5 drain", 0, 0, 1, 16'h0020);
  endtask

  task automatic t_ovf();
    arm(0, 1, 16'h0, 8'd0, 16'h0030, 8'd2);
    fifo_ovf = 1'b1;
    @(negedge clk);
    fifo_ovf = 1'b0;
    chk("R7 ovf_b set", {ovf_a, ovf_b}, 2'b01);
    push("R7 B0", 0, 0, 1, 16'h0030);
    push("R7 B1", 0, 0, 1, 16'h0031);
    fifo_ovf = 1'b1;
    @(negedge clk);
    fifo_ovf = 1'b0;
    chk("R7 idle pulse dropped", {ovf_a, ovf_b}, 2'b01);
    arm(0, 1, 16'h0, 8'd0, 16'h0040, 8'd1);
    chk("R7 reload clears", ovf_b, 1'b0);
    push("R7 drain", 0, 0, 1, 16'h0040);
  endtask

  task automatic t_ssel();
    spi_mode = 1'b0;
    deassert();
    chk("R12 ignored code", ssel_state, 3'd0);
    chk("R12 ignored count", saved_count, 8'd0);
    spi_mode = 1'b1;
    arm(1, 0, 16'h0050, 8'd4, 16'h0, 8'd0);
    push("R8 A0", 0, 0, 1, 16'h0050);
    push("R8 A1", 0, 0, 1, 16'h0051);
    deassert();
    chk("R9 A once", ssel_state, 3'd2);
    chk("R8 count 2", saved_count, 8'd2);
    deassert();
    chk("R9 A more than once", ssel_state, 3'd6);
    push("R8 A2", 0, 0, 1, 16'h0052);
    push("R8 A3", 0, 0, 1, 16'h0053);
    deassert();
    chk("R8 last written buffer", ssel_state, 3'd6);
    chk("R8 full count", saved_count, 8'd4);
    arm(0, 1, 16'h0, 8'd0, 16'h0060, 8'd3);
    chk("R10 load clears code", ssel_state, 3'd0);
    push("R8 B0", 0, 0, 1, 16'h0060);
    deassert();
    chk("R9 B once", ssel_state, 3'd3);
    chk("R8 B count", saved_count, 8'd1);
    ssel_n = 1'b0;
    @(negedge clk);
    ssel_n = 1'b1;
    arm(1, 0, 16'h0070, 8'd2, 16'h0, 8'd0);
    chk("R10 same-cycle arm and deassert", ssel_state, 3'd3);
    chk("R10 same-cycle count", saved_count, 8'd1);
  endtask

  task automatic t_dmarst();
    push("R11 B1 before reset", 1, 0, 1, 16'h0061);
    chk("R11 pre flags", frm_b, 1'b1);
    dma_reset = 1'b1; arm_a = 1'b1; a_base = 16'h0090; a_len = 8'd1;
    @(negedge clk);
    dma_reset = 1'b0; arm_a = 1'b0;
    chk("R11 loads cleared", {load_a, load_b}, 2'b00);
    chk("R11 flags cleared", {frm_a, frm_b, par_a, par_b, ovf_a, ovf_b}, 6'd0);
    chk("R11 code cleared", ssel_state, 3'd0);
    chk("R11 count cleared", saved_count, 8'd0);
    push("R11 no pop after reset", 0, 0, 0, 16'h0);
    arm(0, 1, 16'h0, 8'd0, 16'h00A0, 8'd1);
    push("R11 pointer restarts", 0, 0, 1, 16'h00A0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_prio();
        t_ping();
        t_err();
        t_ovf();
        t_ssel();
        t_dmarst();
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule